// File: doc/BRIEF.md
# PLL Divider Chain with Offset-Coded Ratios

This block holds the digital dividers that surround an analog phase-locked loop. The reference divider runs on the reference clock and divides it by P+2. The feedback divider and the output scaler both run on the oscillator clock. The feedback divider divides by M+8 and returns its output to the phase comparator. The output scaler divides by 2^S, and for S=0 it passes the oscillator clock through. In lock the synthesized frequency is therefore f_ref × (M+8) / ((P+2) × 2^S).

All three ratios come from one 16-bit configuration word. Each clock domain copies the word into a shadow register when a load strobe arrives, and restarts its counters from zero at that moment. A power-down input stops every divider and holds it cleared. The shadow ratios survive a power-down. The reset, the load strobe and the power-down input are each brought into both clock domains through synchronizers.

Top module: `pll_div_chain`

## Requirements
- R1: The word is split as bits [5:0] = P, [13:6] = M and [15:14] = S. A domain takes the word only on the rising edge of its synchronized cfg_load, and at that edge it clears its counters. A change of cfg_word with no load strobe leaves every output period unchanged.
- R2: ref_div_o has a period of P+2 reference clock cycles, for P from 0 to 63.
- R3: fb_div_o has a period of M+8 oscillator clock cycles, for M from 0 to 255.
- R4: For S = 1, 2 and 3, out_clk_o has a period of 2^S oscillator cycles and is high for half of it.
- R5: With S = 0, out_clk_o follows osc_clk: it is high in the high half of each oscillator cycle and low in the low half.
- R6: For an odd ratio N, the high phase of a divided output lasts (N+1)/2 cycles and the low phase lasts (N-1)/2 cycles.
- R7: While pwrdn is high, all three outputs are low and the counters are held at zero. A load strobe given during power-down still updates the ratios, and those ratios apply after release.
- R8: While rst_n is low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| ref_clk | input | 1 | Reference input clock |
| osc_clk | input | 1 | Oscillator clock |
| pwrdn | input | 1 | Power-down, active high, asynchronous to both clocks |
| cfg_load | input | 1 | Load strobe for the configuration word; hold high for at least 3 cycles of the slower clock |
| cfg_word | input | 16 | Ratio word {S, M, P}; must be stable while a load is in progress |
| ref_div_o | output | 1 | Reference divided by P+2 |
| fb_div_o | output | 1 | Oscillator divided by M+8 |
| out_clk_o | output | 1 | Oscillator divided by 2^S, or passed through for S=0 |

## Verification
A load strobe and power-down can reach a domain in the same cycle. The load must then update the shadow ratios, while power-down must keep the counters cleared. The bench provokes this by raising pwrdn first and then issuing a complete load of a new word while the block is still powered down. It expects all three outputs to stay low throughout. After release, it measures each output's high phase and period and expects the values of the new word.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int P_W   = 6;
  localparam int M_W   = 8;
  localparam int S_W   = 2;
  localparam int CFG_W = P_W + M_W + S_W;
  localparam int P_OFS = 2;
  localparam int M_OFS = 8;

  typedef struct packed {
    logic [S_W-1:0] s;
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
  } cfg_t;
endpackage

// File: rtl/pll_div_sync.sv
module pll_div_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/pll_div_counter.sv
module pll_div_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] ratio_m1,
  output logic         div_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         out_q, out_d;
  logic [W:0]   sum;
  logic [W-1:0] half;

  // high phase length = ceil(N/2) with N = ratio_m1 + 1
  assign sum  = {1'b0, ratio_m1} + (W+1)'(2);
  assign half = sum[W:1];

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (clr) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (en) begin
      cnt_d = (cnt_q >= ratio_m1) ? '0 : cnt_q + W'(1);
      out_d = (cnt_d < half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign div_o = out_q;
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
  import pll_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             osc_clk,
  input  logic             pwrdn,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             ref_div_o,
  output logic             fb_div_o,
  output logic             out_clk_o
);
  localparam int PRE_CW  = $clog2((1 << P_W) + P_OFS);
  localparam int MAIN_CW = $clog2((1 << M_W) + M_OFS);
  localparam int POST_CW = (1 << S_W) - 1;

  cfg_t cfg_in;
  assign cfg_in = cfg_t'(cfg_word);

  // ---------------- reference domain ----------------
  logic ref_rst_n, ref_run, ref_ld_s, ref_ld_q, ref_ld_pulse;
  logic [P_W-1:0] ref_p_q, ref_p_d;

  pll_div_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n));
  pll_div_sync #(.STAGES(SYNC_STAGES)) u_ref_run (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(~pwrdn), .q(ref_run));
  pll_div_sync #(.STAGES(SYNC_STAGES)) u_ref_ld (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(cfg_load), .q(ref_ld_s));

  assign ref_ld_pulse = ref_ld_s & ~ref_ld_q;

  always_comb begin
    ref_p_d = ref_p_q;
    if (ref_ld_pulse) ref_p_d = cfg_in.p;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      ref_ld_q <= 1'b0;
      ref_p_q  <= '0;
    end else begin
      ref_ld_q <= ref_ld_s;
      ref_p_q  <= ref_p_d;
    end
  end

  pll_div_counter #(.W(PRE_CW)) u_pre (
    .clk(ref_clk), .rst_n(ref_rst_n), .en(ref_run),
    .clr(ref_ld_pulse | ~ref_run),
    .ratio_m1(PRE_CW'(ref_p_q) + PRE_CW'(P_OFS - 1)),
    .div_o(ref_div_o));

  // ---------------- oscillator domain ----------------
  logic osc_rst_n, osc_run, osc_ld_s, osc_ld_q, osc_ld_pulse;
  logic [M_W-1:0] osc_m_q, osc_m_d;
  logic [S_W-1:0] osc_s_q, osc_s_d;
  logic           bypass, gate_q, post_div;
  logic [POST_CW-1:0] post_m1;

  pll_div_sync #(.STAGES(SYNC_STAGES)) u_osc_rst (
    .clk(osc_clk), .rst_n(rst_n), .d(1'b1), .q(osc_rst_n));
  pll_div_sync #(.STAGES(SYNC_STAGES)) u_osc_run (
    .clk(osc_clk), .rst_n(osc_rst_n), .d(~pwrdn), .q(osc_run));
  pll_div_sync #(.STAGES(SYNC_STAGES)) u_osc_ld (
    .clk(osc_clk), .rst_n(osc_rst_n), .d(cfg_load), .q(osc_ld_s));

  assign osc_ld_pulse = osc_ld_s & ~osc_ld_q;

  always_comb begin
    osc_m_d = osc_m_q;
    osc_s_d = osc_s_q;
    if (osc_ld_pulse) begin
      osc_m_d = cfg_in.m;
      osc_s_d = cfg_in.s;
    end
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      osc_ld_q <= 1'b0;
      osc_m_q  <= '0;
      osc_s_q  <= '0;
    end else begin
      osc_ld_q <= osc_ld_s;
      osc_m_q  <= osc_m_d;
      osc_s_q  <= osc_s_d;
    end
  end

  pll_div_counter #(.W(MAIN_CW)) u_main (
    .clk(osc_clk), .rst_n(osc_rst_n), .en(osc_run),
    .clr(osc_ld_pulse | ~osc_run),
    .ratio_m1(MAIN_CW'(osc_m_q) + MAIN_CW'(M_OFS - 1)),
    .div_o(fb_div_o));

  assign bypass  = (osc_s_q == '0);
  assign post_m1 = POST_CW'((1 << osc_s_q) - 1);

  pll_div_counter #(.W(POST_CW)) u_post (
    .clk(osc_clk), .rst_n(osc_rst_n), .en(osc_run & ~bypass),
    .clr(osc_ld_pulse | ~osc_run | bypass),
    .ratio_m1(post_m1),
    .div_o(post_div));

  // pass-through enable changes only while osc_clk is low
  always_ff @(negedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) gate_q <= 1'b0;
    else            gate_q <= osc_run & bypass;
  end

  assign out_clk_o = (osc_clk & gate_q) | post_div;
endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk
  import pll_div_pkg::*;
(
  input logic           ref_clk,
  input logic           osc_clk,
  input logic           ref_rst_n,
  input logic           osc_rst_n,
  input logic           ref_run,
  input logic           osc_run,
  input logic           ref_ld_pulse,
  input logic           osc_ld_pulse,
  input logic           ref_div_o,
  input logic           fb_div_o,
  input logic [P_W-1:0] ref_p_q,
  input logic [M_W-1:0] osc_m_q,
  input logic [S_W-1:0] osc_s_q
);
  p_ref_ratio_hold_r1: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !ref_ld_pulse |=> $stable(ref_p_q));

  p_osc_ratio_hold_r1: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    !osc_ld_pulse |=> $stable({osc_m_q, osc_s_q}));

  p_load_restart_r1: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    osc_ld_pulse |=> !fb_div_o);

  p_pd_ref_low_r7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !ref_run |=> !ref_div_o);

  p_pd_fb_low_r7: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    !osc_run |=> !fb_div_o);
endmodule

bind pll_div_chain pll_div_chain_chk u_chk (
  .ref_clk(ref_clk), .osc_clk(osc_clk),
  .ref_rst_n(ref_rst_n), .osc_rst_n(osc_rst_n),
  .ref_run(ref_run), .osc_run(osc_run),
  .ref_ld_pulse(ref_ld_pulse), .osc_ld_pulse(osc_ld_pulse),
  .ref_div_o(ref_div_o), .fb_div_o(fb_div_o),
  .ref_p_q(ref_p_q), .osc_m_q(osc_m_q), .osc_s_q(osc_s_q));

// File: tb/pll_div_chain_tb.sv
`timescale 1ns/1ps
module pll_div_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 26;
  localparam int WATCHDOG   = 150000 * CLK_PERIOD;

  logic rst_n, ref_clk, osc_clk, pwrdn, cfg_load;
  logic [15:0] cfg_word;
  logic ref_div_o, fb_div_o, out_clk_o;

  pll_div_chain u_dut (
    .rst_n(rst_n), .ref_clk(ref_clk), .osc_clk(osc_clk), .pwrdn(pwrdn),
    .cfg_load(cfg_load), .cfg_word(cfg_word),
    .ref_div_o(ref_div_o), .fb_div_o(fb_div_o), .out_clk_o(out_clk_o));

  initial osc_clk = 1'b0;
  always #(CLK_PERIOD/2.0) osc_clk = ~osc_clk;
  initial ref_clk = 1'b0;
  always #(REF_PERIOD/2.0) ref_clk = ~ref_clk;

  typedef struct {int sel; int hi; int per; string req;} item_t;
  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel: 0 ref_div_o, 1 fb_div_o, 2 out_clk_o divided, 3 out_clk_o bypass
  function automatic logic sample(input int sel);
    case (sel)
      0: return ref_div_o;
      1: return fb_div_o;
      default: return out_clk_o;
    endcase
  endfunction

  task automatic tick(input int sel);
    if (sel == 0) begin @(posedge ref_clk); #(REF_PERIOD/4.0); end
    else begin @(posedge osc_clk); #(CLK_PERIOD/4.0); end
  endtask

  task automatic measure(input int sel, output int hi, output int lo);
    logic prv, cur;
    int g;
    g = 0;
    tick(sel); prv = sample(sel);
    forever begin
      tick(sel); cur = sample(sel);
      if (!prv && cur) break;
      prv = cur; g++;
      if (g > 4000) break;
    end
    hi = 1;
    forever begin tick(sel); if (!sample(sel)) break; hi++; if (hi > 4000) break; end
    lo = 1;
    forever begin tick(sel); if (sample(sel)) break; lo++; if (lo > 4000) break; end
  endtask

  // monitor: pops expected items and compares against measured waveforms
  initial begin
    item_t it;
    int hi, lo;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q[0];
      if (it.sel == 3) begin
        for (int k = 0; k < 4; k++) begin
          @(posedge osc_clk); #(CLK_PERIOD/4.0);
          check(out_clk_o === 1'b1, {it.req, " bypass high half"}, out_clk_o, 1);
          @(negedge osc_clk); #(CLK_PERIOD/4.0);
          check(out_clk_o === 1'b0, {it.req, " bypass low half"}, out_clk_o, 0);
        end
      end else begin
        measure(it.sel, hi, lo);
        check(hi == it.hi, {it.req, " high phase"}, hi, it.hi);
        check(hi + lo == it.per, {it.req, " period"}, hi + lo, it.per);
      end
      void'(sb_q.pop_front());
    end
  end

  task automatic push(input int sel, input int hi, input int per, input string req);
    item_t it;
    it.sel = sel; it.hi = hi; it.per = per; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic expect_cfg(input int p, input int m, input int s,
                            input string tr, input string tf, input string to);
    push(0, (p + 3) / 2, p + 2, tr);
    push(1, (m + 9) / 2, m + 8, tf);
    if (s == 0) push(3, 1, 1, to);
    else        push(2, 1 << (s - 1), 1 << s, to);
    wait (sb_q.size() == 0);
  endtask

  task automatic configure(input int p, input int m, input int s);
    @(negedge ref_clk);
    cfg_word = {s[1:0], m[7:0], p[5:0]};
    cfg_load = 1'b1;
    repeat (4) @(negedge ref_clk);
    cfg_load = 1'b0;
    repeat (8) @(negedge ref_clk);
  endtask

  task automatic check_all_low(input string req);
    for (int k = 0; k < 6; k++) begin
      @(posedge osc_clk); #(CLK_PERIOD/4.0);
      check(ref_div_o === 1'b0, {req, " ref_div_o low"}, ref_div_o, 0);
      check(fb_div_o  === 1'b0, {req, " fb_div_o low"}, fb_div_o, 0);
      check(out_clk_o === 1'b0, {req, " out_clk_o low"}, out_clk_o, 0);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(WATCHDOG);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pwrdn = 1'b0; cfg_load = 1'b0; cfg_word = '0;
    repeat (5) @(negedge ref_clk);
    check_all_low("R8");                       // reset state
    @(negedge ref_clk); rst_n = 1'b1;
    repeat (6) @(negedge ref_clk);

    configure(0, 0, 1);                        // minimum ratios
    expect_cfg(0, 0, 1, "R2 P=0", "R3 M=0", "R4 S=1");

    configure(63, 255, 3);                     // maximum ratios (odd feedback 263)
    expect_cfg(63, 255, 3, "R2 P=63", "R3 M=255 R6", "R4 S=3");

    configure(5, 3, 2);                        // odd ratios 7 and 11
    expect_cfg(5, 3, 2, "R6 ref N=7", "R6 fb N=11", "R4 S=2");

    configure(1, 1, 0);                        // bypass scaler
    expect_cfg(1, 1, 0, "R2 P=1", "R3 M=1", "R5 S=0");

    configure(5, 3, 2);
    cfg_word = {2'd1, 8'd100, 6'd20};          // no load strobe: must be ignored
    repeat (20) @(negedge ref_clk);
    expect_cfg(5, 3, 2, "R1 ref unchanged", "R1 fb unchanged", "R1 out unchanged");

    pwrdn = 1'b1;                              // power-down, then load while down
    repeat (6) @(negedge ref_clk);
    check_all_low("R7 powered down");
    configure(2, 10, 1);
    check_all_low("R7 load during power-down");
    pwrdn = 1'b0;
    repeat (10) @(negedge ref_clk);
    expect_cfg(2, 10, 1, "R7 ref after release", "R7 fb after release", "R7 out after release");

    finish_run();
  end
endmodule